// File: doc/BRIEF.md
# UART Interrupt Enable and Identification

This block is the interrupt front end of a 16550-style serial port. The receive and transmit datapath reports five raw event conditions: received data available, character time-out, transmitter holding register empty, receiver line status, and modem status. The block keeps a four-bit enable register that masks those conditions. It then picks the single most urgent enabled condition and presents it as an identification byte that software can read. It also drives a registered interrupt request line.

The transmitter-empty condition arrives as a one-cycle event and is held in a pending latch. That latch clears when software reads the identification byte while it names that condition, or when software writes the holding register. The other four conditions are level inputs owned by the datapath. A FIFO-mode input changes two things: the top two bits of the identification byte, and whether the time-out condition is seen at all.

Top module: `uart_irq_front`

## Requirements
- R1: After reset, the enable readback is 0x00, the identification byte is 0x01 with FIFO mode off, and `intr` is 0.
- R2: A write on `en_wr` stores `en_wdata[3:0]` into the enable register. The enable readback shows those four bits in bits 3:0 and returns 0 in bits 7:4. Bit 0 enables data-available and time-out, bit 1 transmitter-empty, bit 2 line status, bit 3 modem status.
- R3: Identification bit 0 is 0 while any enabled condition is pending and 1 when none is pending.
- R4: Identification bits 3:1 name the winning condition. Priority from highest to lowest is: line status 011, data available 010, time-out 110, transmitter empty 001, modem status 000. Data available beats time-out when both are active.
- R5: Time-out is recognised only with FIFO mode on. It then reads with bits 3 and 2 both set. With FIFO mode off, bit 3 is always 0 and a time-out input has no effect.
- R6: A condition whose enable bit is 0 does not appear in the identification byte and does not raise `intr`.
- R7: A one-cycle `thr_empty_evt` sets the transmitter-empty latch. A write on `thr_wr` clears it. When an event and a clear occur in the same cycle, the event wins.
- R8: A pulse on `id_rd` clears the transmitter-empty latch only if the identification byte names transmitter-empty in that cycle. When a higher-priority condition is showing, the latch stays set.
- R9: `intr` is registered. In each cycle it equals the "any enabled condition pending" value of the previous cycle.
- R10: Identification bits 7:6 are 11 with FIFO mode on and 00 with it off. Bits 5:4 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | FIFO mode enabled |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Write data for the enable register |
| id_rd | input | 1 | Read strobe for the identification byte |
| thr_wr | input | 1 | Holding register write, clears transmitter-empty |
| rx_avail | input | 1 | Received data available (level) |
| rx_timeout | input | 1 | Character time-out (level) |
| thr_empty_evt | input | 1 | Transmitter holding empty event (pulse) |
| line_stat | input | 1 | Receiver line status condition (level) |
| modem_stat | input | 1 | Modem status condition (level) |
| ier_rdata | output | 8 | Enable register readback |
| iir_rdata | output | 8 | Identification byte |
| intr | output | 1 | Interrupt request |

## Verification
The assertions assume that the strobe inputs are single-cycle and synchronous to `clk`. They also assume `fifo_mode` is a clean level that does not go unknown after reset. The bench meets both assumptions by driving every input at the falling edge and returning each strobe to 0 one cycle later. It changes FIFO mode only between scenarios. The condition inputs are free levels, and the bench deliberately overlaps them to exercise priority and masking.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int SRC_N = 5;

  // grant vector bit positions, highest priority first
  localparam int G_RLS  = 0;
  localparam int G_RDA  = 1;
  localparam int G_CTO  = 2;
  localparam int G_THRE = 3;
  localparam int G_MSR  = 4;

  typedef enum logic [2:0] {
    ID_MSR  = 3'b000,
    ID_THRE = 3'b001,
    ID_RDA  = 3'b010,
    ID_RLS  = 3'b011,
    ID_CTO  = 3'b110
  } irq_id_e;

  function automatic irq_id_e id_of_grant(logic [SRC_N-1:0] g);
    irq_id_e r;
    r = ID_MSR;
    if (g[G_RLS])       r = ID_RLS;
    else if (g[G_RDA])  r = ID_RDA;
    else if (g[G_CTO])  r = ID_CTO;
    else if (g[G_THRE]) r = ID_THRE;
    return r;
  endfunction

  function automatic logic [7:0] build_iir(irq_id_e id, logic pend, logic fifo);
    return {{2{fifo}}, 2'b00, id, ~pend};
  endfunction
endpackage

// File: rtl/uart_irq_enable_reg.sv
module uart_irq_enable_reg #(
  parameter int DATA_W = 8,
  parameter int EN_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [EN_W-1:0]   en_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - EN_W;

  logic unused_hi;
  assign unused_hi = ^wdata[DATA_W-1:EN_W];

  always_ff @(posedge clk) begin
    if (!rst_n)  en_q <= '0;
    else if (wr) en_q <= wdata[EN_W-1:0];
  end

  assign rdata = {{PAD_W{1'b0}}, en_q};

  assert_en_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (en_q == $past(wdata[EN_W-1:0])));
endmodule

// File: rtl/uart_irq_thre_latch.sv
module uart_irq_thre_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_wr,
  input  logic clr_rd,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (!rst_n)                pend <= 1'b0;
    else if (set_evt)          pend <= 1'b1;
    else if (clr_wr || clr_rd) pend <= 1'b0;
  end

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd && !set_evt) |=> !pend);
  assert_event_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> pend);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int EN_W = 4
) (
  input  logic [EN_W-1:0]  en,
  input  logic             fifo,
  input  logic             rls,
  input  logic             rda,
  input  logic             cto,
  input  logic             thre,
  input  logic             msr,
  output logic [SRC_N-1:0] grant,
  output irq_id_e          id,
  output logic             pend
);
  logic [SRC_N-1:0] req;

  always_comb begin
    req         = '0;
    req[G_RLS]  = rls  & en[2];
    req[G_RDA]  = rda  & en[0];
    req[G_CTO]  = cto  & fifo & en[0];
    req[G_THRE] = thre & en[1];
    req[G_MSR]  = msr  & en[3];
  end

  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < SRC_N; i++) begin
      if (req[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  assign pend = |req;
  assign id   = id_of_grant(grant);
endmodule

// File: rtl/uart_irq_front.sv
module uart_irq_front
  import uart_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int EN_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode,
  input  logic              en_wr,
  input  logic [DATA_W-1:0] en_wdata,
  input  logic              id_rd,
  input  logic              thr_wr,
  input  logic              rx_avail,
  input  logic              rx_timeout,
  input  logic              thr_empty_evt,
  input  logic              line_stat,
  input  logic              modem_stat,
  output logic [DATA_W-1:0] ier_rdata,
  output logic [7:0]        iir_rdata,
  output logic              intr
);
  logic [EN_W-1:0]  en_q;
  logic             thre_pend;
  logic [SRC_N-1:0] grant;
  irq_id_e          win_id;
  logic             any_pend;
  logic             thre_read_clr;

  uart_irq_enable_reg #(.DATA_W(DATA_W), .EN_W(EN_W)) u_en (
    .clk(clk), .rst_n(rst_n), .wr(en_wr), .wdata(en_wdata),
    .en_q(en_q), .rdata(ier_rdata)
  );

  uart_irq_prio #(.EN_W(EN_W)) u_prio (
    .en(en_q), .fifo(fifo_mode), .rls(line_stat), .rda(rx_avail),
    .cto(rx_timeout), .thre(thre_pend), .msr(modem_stat),
    .grant(grant), .id(win_id), .pend(any_pend)
  );

  assign thre_read_clr = id_rd & grant[G_THRE];

  uart_irq_thre_latch u_thre (
    .clk(clk), .rst_n(rst_n), .set_evt(thr_empty_evt), .clr_wr(thr_wr),
    .clr_rd(thre_read_clr), .pend(thre_pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) intr <= 1'b0;
    else        intr <= any_pend;
  end

  assign iir_rdata = build_iir(win_id, any_pend, fifo_mode);

  assert_one_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_all_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !intr);
  assert_no_cto_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> !iir_rdata[3]);
  assert_cto_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    iir_rdata[3] |-> iir_rdata[2]);
  assert_pend_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |-> iir_rdata[0]);
endmodule

// File: tb/test_uart_irq_front.sv
module test_uart_irq_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_mode = 0, en_wr = 0, id_rd = 0, thr_wr = 0;
  logic rx_avail = 0, rx_timeout = 0, thr_empty_evt = 0, line_stat = 0, modem_stat = 0;
  logic [7:0] en_wdata = 8'h00;
  logic [7:0] ier_rdata, iir_rdata;
  logic intr;

  always #5 clk = ~clk;

  uart_irq_front i_uart_irq_front (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .en_wr(en_wr),
    .en_wdata(en_wdata), .id_rd(id_rd), .thr_wr(thr_wr), .rx_avail(rx_avail),
    .rx_timeout(rx_timeout), .thr_empty_evt(thr_empty_evt), .line_stat(line_stat),
    .modem_stat(modem_stat), .ier_rdata(ier_rdata), .iir_rdata(iir_rdata), .intr(intr)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_ier = 0;
  bit m_thre = 0, m_intr = 0;

  // 0 none, 1 line, 2 data, 3 timeout, 4 thre, 5 modem
  function automatic int ref_src();
    if (line_stat && m_ier[2]) return 1;
    if (rx_avail && m_ier[0]) return 2;
    if (fifo_mode && rx_timeout && m_ier[0]) return 3;
    if (m_thre && m_ier[1]) return 4;
    if (modem_stat && m_ier[3]) return 5;
    return 0;
  endfunction

  function automatic int ref_iir();
    int v;
    case (ref_src())
      1: v = 6; 2: v = 4; 3: v = 12; 4: v = 2; 5: v = 0; default: v = 1;
    endcase
    if (fifo_mode) v += 192;
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // compare at mid-cycle, then advance one clock and update the model
  task automatic tick();
    int src;
    #1;
    check({cur_req, " id"}, int'(iir_rdata), ref_iir());
    check({cur_req, " en"}, int'(ier_rdata), m_ier);
    check({cur_req, " R9 intr"}, int'(intr), int'(m_intr));
    src = ref_src();
    @(posedge clk);
    m_intr = (src != 0);
    if (thr_empty_evt) m_thre = 1;
    else if (thr_wr || (id_rd && src == 4)) m_thre = 0;
    if (en_wr) m_ier = int'(en_wdata) % 16;
    @(negedge clk);
  endtask

  task automatic wr_en(logic [7:0] d);
    en_wr = 1; en_wdata = d; tick(); en_wr = 0; en_wdata = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 reset en", int'(ier_rdata), 0);
    check("R1 reset id", int'(iir_rdata), 8'h01);
    check("R1 reset intr", int'(intr), 0);
    @(negedge clk);
    tick();

    cur_req = "R2";
    wr_en(8'hFF); #1; check("R2 upper bits zero", int'(ier_rdata), 8'h0F); @(negedge clk);
    wr_en(8'hA5); #1; check("R2 store", int'(ier_rdata), 8'h05); @(negedge clk);

    cur_req = "R6";
    wr_en(8'h00);
    line_stat = 1; rx_avail = 1; modem_stat = 1; thr_empty_evt = 1; tick(); thr_empty_evt = 0;
    tick();
    #1; check("R6 all masked id", int'(iir_rdata), 8'h01);
    check("R6 all masked intr", int'(intr), 0); @(negedge clk);
    wr_en(8'h08); tick();
    #1; check("R6 only modem shows", int'(iir_rdata), 8'h00);
    check("R9 intr after enable", int'(intr), 1); @(negedge clk);

    cur_req = "R4";
    wr_en(8'h0F); tick();
    #1; check("R4 line wins", int'(iir_rdata), 8'h06);
    check("R3 pending flag low", int'(iir_rdata[0]), 0); @(negedge clk);
    line_stat = 0; tick();
    #1; check("R4 data next", int'(iir_rdata), 8'h04); @(negedge clk);
    rx_avail = 0; tick();
    #1; check("R4 thre next", int'(iir_rdata), 8'h02); @(negedge clk);

    cur_req = "R8";
    line_stat = 1; id_rd = 1; tick(); id_rd = 0; line_stat = 0; tick();
    #1; check("R8 read under line keeps thre", int'(iir_rdata), 8'h02); @(negedge clk);
    id_rd = 1; tick(); id_rd = 0; tick();
    #1; check("R8 read clears thre", int'(iir_rdata), 8'h00); @(negedge clk);

    cur_req = "R7";
    thr_empty_evt = 1; tick(); thr_empty_evt = 0; tick();
    thr_wr = 1; tick(); thr_wr = 0; tick();
    #1; check("R7 write clears", int'(iir_rdata), 8'h00); @(negedge clk);
    thr_empty_evt = 1; tick(); thr_empty_evt = 0;
    thr_empty_evt = 1; thr_wr = 1; id_rd = 1; tick();
    thr_empty_evt = 0; thr_wr = 0; id_rd = 0; tick();
    #1; check("R7 event beats clear", int'(iir_rdata), 8'h02); @(negedge clk);
    thr_wr = 1; tick(); thr_wr = 0;
    modem_stat = 0; tick();
    #1; check("R3 none pending", int'(iir_rdata), 8'h01); @(negedge clk);
    tick();

    cur_req = "R5";
    rx_timeout = 1; tick();
    #1; check("R5 timeout ignored non-FIFO", int'(iir_rdata), 8'h01); @(negedge clk);
    fifo_mode = 1; tick();
    #1; check("R5 timeout in FIFO", int'(iir_rdata), 8'hCC); @(negedge clk);
    rx_avail = 1; tick();
    #1; check("R4 data beats timeout", int'(iir_rdata), 8'hC4); @(negedge clk);
    rx_avail = 0; rx_timeout = 0; tick();
    cur_req = "R10";
    #1; check("R10 FIFO idle", int'(iir_rdata), 8'hC1); @(negedge clk);
    wr_en(8'h0E); rx_timeout = 1; tick();
    #1; check("R6 timeout masked by bit0", int'(iir_rdata), 8'hC1); @(negedge clk);
    rx_timeout = 0; fifo_mode = 0; tick();
    #1; check("R10 non-FIFO top bits", int'(iir_rdata), 8'h01); @(negedge clk);

    cur_req = "R9";
    line_stat = 1; tick();
    #1; check("R9 intr one cycle late", int'(intr), 1); @(negedge clk);
    line_stat = 0; tick();
    #1; check("R9 intr falls", int'(intr), 0); @(negedge clk);
    repeat (4) tick();
    finish_run();
  end
endmodule